// File: doc/BRIEF.md
# Row-Pair XNOR Match Engine

This block holds a small array of bit rows and compares two of them in one operation. A start strobe captures two row addresses, a mode and a search key. The engine then steps through a fixed sequence of four phases: line precharge, evaluate, sense/hold and restore. The result is a per-column XNOR vector plus a flag that is set when every column matches.

In compute mode the two operands are two stored rows, which gives a bitwise binary product in one pass. In search mode the second operand is the supplied key instead of a stored row, so the same evaluation acts as a content-addressable compare. Rows are loaded through a write port and read back through a registered read port. Neither port disturbs the array during compute.

Top module: `xnor_pair_engine`

## Requirements
- R1: In compute mode (`cam_mode`=0), `result[c]` equals the XNOR of bit c of row `row_a` and bit c of row `row_b`, for every column c.
- R2: An accepted start is followed by exactly four busy cycles: precharge, evaluate, sense/hold and restore, one clock each. `busy` is low before and after these cycles.
- R3: `done` is high for exactly one cycle. That cycle is the restore cycle, the fourth cycle after the clock edge that accepted the start.
- R4: `match` equals the AND of all `result` bits. Both outputs take their new value in the sense/hold cycle and keep it unchanged until the sense/hold cycle of the next operation.
- R5: In search mode (`cam_mode`=1), `result[c]` is the XNOR of bit c of row `row_a` and bit c of `key`. `row_b` has no effect.
- R6: A start seen while `busy` is high is ignored. The running operation keeps its operands and its timing.
- R7: When `row_a` equals `row_b` in compute mode, `result` is all ones and `match` is 1.
- R8: When `wr_en` is high and the engine is idle, `wr_data` is stored at row `wr_addr`. `rd_data` shows row `rd_addr` one clock after the address is sampled.
- R9: A write request while `busy` is high is ignored. An operation, including its restore phase, leaves every stored row unchanged.
- R10: Reset clears `result`, `match`, `done` and `busy` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Row write request |
| wr_addr | input | AW | Row written |
| wr_data | input | COLS | Data written |
| rd_addr | input | AW | Row read |
| rd_data | output | COLS | Registered read data |
| start | input | 1 | Operation strobe |
| cam_mode | input | 1 | 0 compute (row vs row), 1 search (row vs key) |
| row_a | input | AW | First operand row |
| row_b | input | AW | Second operand row (compute mode) |
| key | input | COLS | Search pattern (search mode) |
| result | output | COLS | Per-column XNOR |
| match | output | 1 | All columns match |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Restore-cycle completion pulse |

## Verification
The properties assume that `start`, `wr_en` and the operand inputs are clean, known values at every clock edge after reset. They also assume that rows are not written in the same cycle that a start is accepted, so operand rows are stable through the evaluate phase. The bench changes every input on the falling clock edge. It issues writes only while the engine is idle, except for writes it raises on purpose during an operation to show they are dropped. It keeps a row mirror that follows exactly the writes the requirements allow.

// File: rtl/xnor_pair_engine.sv
module xnor_pair_engine #(
  parameter int ROWS = 16,
  parameter int COLS = 32,
  localparam int AW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [COLS-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [COLS-1:0] rd_data,
  input  logic            start,
  input  logic            cam_mode,
  input  logic [AW-1:0]   row_a,
  input  logic [AW-1:0]   row_b,
  input  logic [COLS-1:0] key,
  output logic [COLS-1:0] result,
  output logic            match,
  output logic            busy,
  output logic            done
);
  typedef enum logic [2:0] {PH_IDLE, PH_PRE, PH_EVAL, PH_SENSE, PH_REST} phase_t;

  phase_t          phase;
  logic [COLS-1:0] mem [ROWS];
  logic [AW-1:0]   sel_a, sel_b;
  logic            srch;
  logic [COLS-1:0] key_q, line, opnd_b, agree;

  assign busy   = (phase != PH_IDLE);
  assign done   = (phase == PH_REST);
  assign opnd_b = srch ? key_q : mem[sel_b];
  assign agree  = ~(mem[sel_a] ^ opnd_b);

  always_ff @(posedge clk) begin
    if (wr_en && !busy) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      sel_a  <= '0;
      sel_b  <= '0;
      srch   <= 1'b0;
      key_q  <= '0;
      line   <= '0;
      result <= '0;
      match  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          sel_a <= row_a;
          sel_b <= row_b;
          srch  <= cam_mode;
          key_q <= key;
          phase <= PH_PRE;
        end
        PH_PRE: begin
          line  <= '1;
          phase <= PH_EVAL;
        end
        PH_EVAL: begin
          line   <= line & agree;
          result <= line & agree;
          match  <= &(line & agree);
          phase  <= PH_SENSE;
        end
        PH_SENSE: phase <= PH_REST;
        default: begin
          line  <= '0;
          phase <= PH_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/xnor_pair_engine_chk.sv
module xnor_pair_engine_chk #(
  parameter int ROWS = 16,
  parameter int COLS = 32,
  localparam int AW = $clog2(ROWS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            cam_mode,
  input logic [AW-1:0]   row_a,
  input logic [AW-1:0]   row_b,
  input logic [COLS-1:0] result,
  input logic            match,
  input logic            busy,
  input logic            done
);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy && $past(busy, 1) && $past(busy, 2) && $past(busy, 3) && !$past(busy, 4));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result) && $stable(match));

  assert_match_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (match == (&result)));

  assert_same_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !cam_mode && row_a == row_b) |=> ##2 (match && (&result)));

  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind xnor_pair_engine xnor_pair_engine_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (.*);

// File: tb/test_xnor_pair_engine.sv
module test_xnor_pair_engine;
  localparam int ROWS = 16;
  localparam int COLS = 32;
  localparam int AW = $clog2(ROWS);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, start = 0, cam_mode = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0, row_a = '0, row_b = '0;
  logic [COLS-1:0] wr_data = '0, key = '0;
  logic [COLS-1:0] rd_data, result;
  logic match, busy, done;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic [COLS-1:0] model [ROWS];
  logic [COLS:0] expq [$];

  always #4 clk = ~clk;

  xnor_pair_engine #(.ROWS(ROWS), .COLS(COLS)) i_xnor_pair_engine (.*);

  task automatic check(string req, logic [COLS:0] act, logic [COLS:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_row(logic [AW-1:0] a, logic [COLS-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model[a] = d;
  endtask

  task automatic read_check(logic [AW-1:0] a, string req);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(req, {1'b0, rd_data}, {1'b0, model[a]});
  endtask

  // R1 R5: expected XNOR computed from the mirror
  task automatic run_op(logic [AW-1:0] a, logic [AW-1:0] b, logic cm,
                        logic [COLS-1:0] k, bit poke_start, bit poke_write);
    logic [COLS-1:0] e;
    e = ~(model[a] ^ (cm ? k : model[b]));
    expq.push_back({&e, e});
    @(negedge clk);
    start = 1; row_a = a; row_b = b; cam_mode = cm; key = k;
    @(negedge clk);
    start = 0;
    check("R2 busy precharge", {{COLS{1'b0}}, busy}, {{COLS{1'b0}}, 1'b1});
    if (poke_write) begin wr_en = 1; wr_addr = a; wr_data = ~model[a]; end
    @(negedge clk);
    wr_en = 0;
    check("R2 busy evaluate", {{COLS{1'b0}}, busy}, {{COLS{1'b0}}, 1'b1});
    if (poke_start) begin start = 1; row_a = a + 1'b1; row_b = b + 2'd2; cam_mode = ~cm; key = ~k; end
    @(negedge clk);
    start = 0;
    check("R4 valid in sense", {&e, e}, {match, result});
    check("R3 no done in sense", {{COLS{1'b0}}, done}, '0);
    @(negedge clk);
    check("R3 done in restore", {{COLS{1'b0}}, done & busy}, {{COLS{1'b0}}, 1'b1});
    @(negedge clk);
    check("R2 idle after restore", {{COLS{1'b0}}, busy | done}, '0);
    check("R4 held after op", {match, result}, {&e, e});
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expq.size() == 0) check("R3 unexpected done", 1, 0);
      else check("R1/R5 scoreboard", {match, result}, expq.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", {match, result}, '0);
    check("R10 reset flags", {{COLS{1'b0}}, busy | done}, '0);
    rst_n = 1;
    for (int r = 0; r < ROWS; r++) write_row(r[AW-1:0], {r[7:0] * 8'h3b, 8'hc5 ^ r[7:0], r[7:0], 8'h96});
    read_check(4'd3, "R8 readback");
    read_check(4'd12, "R8 readback");
    run_op(4'd1, 4'd2, 0, '0, 0, 0);           // R1
    run_op(4'd5, 4'd9, 0, '0, 0, 0);           // R1
    write_row(4'd6, 32'hffff_0000);
    write_row(4'd7, 32'h0000_ffff);
    run_op(4'd6, 4'd7, 0, '0, 0, 0);           // R1 all mismatch
    run_op(4'd4, 4'd4, 0, '0, 0, 0);           // R7
    check("R7 match", {{COLS{1'b0}}, match}, {{COLS{1'b0}}, 1'b1});
    run_op(4'd3, 4'd0, 1, model[3], 0, 0);     // R5 exact key hit
    run_op(4'd3, 4'd0, 1, model[3] ^ 32'h0000_0100, 0, 0); // R5 one-bit miss
    check("R5 miss flag", {{COLS{1'b0}}, match}, '0);
    run_op(4'd8, 4'd10, 0, '0, 1, 0);          // R6
    run_op(4'd11, 4'd13, 0, '0, 0, 1);         // R9 write while busy
    read_check(4'd11, "R9 write dropped");
    read_check(4'd13, "R9 restore unchanged");
    repeat (3) @(negedge clk);
    check("R4 held while idle", {match, result}, {&(~(model[11] ^ model[13])), ~(model[11] ^ model[13])});
    check("R3 queue drained", expq.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule